// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block produces the column addresses of one SDRAM read or write burst, one column per clock. A mode word is written into the block once, while no burst runs. The block decodes that word into a burst length, an ordering and a single-beat-write option. A start pulse carries a starting column and a read/write flag. From the clock after the start, the block drives the current column with a valid flag. A last flag marks the final beat of every finite burst.

The controller around the block can end a burst early in two ways: a burst-stop request or a precharge request for the open row. Either request ends the burst at any programmed length. A new start pulse during a burst drops the old burst and begins the new one at once. The command pins, the data path and the read-latency delay belong to the surrounding controller.

Top module: `sdram_col_burst_gen`

## Requirements
- R1: After a synchronous active-low reset, `col_valid`, `col_last` and `mode_err` are 0.
- R2: Mode bits [2:0] select the length: 000 is 1 beat, 001 is 2, 010 is 4, 011 is 8 and 111 is a full page. `col_last` is 1 on the final beat of a finite burst only, and `col_valid` falls on the next cycle.
- R3: With mode bit 3 at 0 (sequential), beat i emits column bits [log2(L)-1:0] = (start + i) mod L, which wraps inside the aligned block. For example, start 2 with L=4 gives 2,3,0,1.
- R4: With mode bit 3 at 1 (interleave), beat i emits low bits = (start low bits) XOR i. For example, start 1 with L=8 gives 1,0,3,2,5,4,7,6.
- R5: The column bits above the burst block keep the start value for the whole burst.
- R6: A full-page burst steps through every column of the page and wraps from the top column to 0. It never raises `col_last` and runs until it is ended.
- R7: With mode bit 9 at 1, a write burst (`start_wr`=1) has one beat. A read burst keeps the programmed length.
- R8: `stop_req` during a burst, without `start`, ends the burst at any length: `col_valid` is 0 on the next cycle.
- R9: `pre_req` during a burst, without `start`, also ends it on the next cycle.
- R10: A reserved length code (100, 101, 110) sets `mode_err` and runs bursts of one beat.
- R11: Full page with mode bit 3 at 1 sets `mode_err` and uses sequential order.
- R12: `start` during a burst drops the old burst. On the next cycle `col_out` shows the new start column as beat 0.
- R13: `stop_req` or `pre_req` while no burst runs has no effect: `col_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_we | input | 1 | Loads `mode_in` into the mode register |
| mode_in | input | MODE_W | Mode word: [2:0] length, [3] ordering, [9] single-beat writes |
| start | input | 1 | Starts a burst at `start_col` |
| start_col | input | COL_W | Starting column |
| start_wr | input | 1 | 1 for a write burst, 0 for a read burst |
| stop_req | input | 1 | Burst-stop request |
| pre_req | input | 1 | Precharge request that ends the burst |
| col_out | output | COL_W | Current column |
| col_valid | output | 1 | `col_out` holds a beat of a burst |
| col_last | output | 1 | Final beat of a finite burst |
| mode_err | output | 1 | The loaded mode word holds an illegal combination |

## Verification
The checks assume that the mode register is written only while no burst runs. They also assume that a start, stop or precharge input is held for exactly one clock. The bench loads the mode word and waits an idle cycle before each start. It drives every pulse on the falling edge for one cycle and clears it on the next falling edge. A start in the same cycle as a stop or precharge request is outside the stop properties, and the bench never drives that case.

// File: rtl/burst_col_pkg.sv
// Shared constants for the burst column sequencer.
// Assumes mode words at least 10 bits wide.
package burst_col_pkg;
    localparam int MB_LEN_LO = 0;
    localparam int MB_LEN_HI = 2;
    localparam int MB_ILV    = 3;
    localparam int MB_SWR    = 9;

    typedef enum logic [2:0] {
        LEN_1    = 3'b000,
        LEN_2    = 3'b001,
        LEN_4    = 3'b010,
        LEN_8    = 3'b011,
        LEN_PAGE = 3'b111
    } len_code_e;

    typedef struct packed {
        logic [1:0] lg;      // log2 of a finite length
        logic       full;    // full-page burst
        logic       ilv;     // interleaved order
        logic       swr;     // single-beat writes
    } burst_cfg_t;
endpackage

// File: rtl/burst_mode_reg.sv
// Holds the mode word and decodes it into the burst settings.
// Assumes the mode word is loaded only while no burst runs.
module burst_mode_reg
    import burst_col_pkg::*;
#(
    parameter int MODE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_in,
    output burst_cfg_t        cfg,
    output logic              err
);
    logic [MODE_W-1:0] mode_q;
    burst_cfg_t        dec;
    logic              dec_err;

    // Keep the last mode word that was written.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= '0;
        else if (mode_we) mode_q <= mode_in;
    end

    // Turn the stored word into settings; flag illegal combinations.
    always_comb begin
        dec     = '0;
        dec_err = 1'b0;
        dec.ilv = mode_q[MB_ILV];
        dec.swr = mode_q[MB_SWR];
        case (mode_q[MB_LEN_HI:MB_LEN_LO])
            LEN_1:    dec.lg = 2'd0;
            LEN_2:    dec.lg = 2'd1;
            LEN_4:    dec.lg = 2'd2;
            LEN_8:    dec.lg = 2'd3;
            LEN_PAGE: begin
                dec.full = 1'b1;
                if (mode_q[MB_ILV]) begin
                    dec.ilv = 1'b0;
                    dec_err = 1'b1;
                end
            end
            default: begin
                dec.lg  = 2'd0;
                dec_err = 1'b1;
            end
        endcase
    end

    assign cfg = dec;
    assign err = dec_err;
endmodule

// File: rtl/burst_beat_ctl.sv
// Tracks the running burst: active flag, beat count and the settings
// captured at start. A start pulse takes priority over a stop request.
// Assumes the column mapper reports the final beat through last_beat.
module burst_beat_ctl
    import burst_col_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  burst_cfg_t       cfg,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic             start_wr,
    input  logic             stop_req,
    input  logic             pre_req,
    input  logic             last_beat,
    output logic             active,
    output logic [COL_W-1:0] beat,
    output logic [COL_W-1:0] base_col,
    output logic [1:0]       lg,
    output logic             full,
    output logic             ilv
);
    logic one_beat_wr;

    // A write burst is forced to one beat when single-beat writes are on.
    assign one_beat_wr = start_wr & cfg.swr;

    // Start, advance or end the burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            beat     <= '0;
            base_col <= '0;
            lg       <= '0;
            full     <= 1'b0;
            ilv      <= 1'b0;
        end else if (start) begin
            active   <= 1'b1;
            beat     <= '0;
            base_col <= start_col;
            lg       <= one_beat_wr ? 2'd0 : cfg.lg;
            full     <= one_beat_wr ? 1'b0 : cfg.full;
            ilv      <= cfg.ilv;
        end else if (active) begin
            if (stop_req || pre_req || last_beat) active <= 1'b0;
            beat <= beat + COL_W'(1);
        end
    end
endmodule

// File: rtl/burst_col_map.sv
// Maps a beat number to a column: sequential or XOR order inside the
// aligned block of the burst length, or a plain page walk.
// Assumes COL_W is at least 3 so that an 8-beat block fits.
module burst_col_map #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base_col,
    input  logic [COL_W-1:0] beat,
    input  logic [1:0]       lg,
    input  logic             full,
    input  logic             ilv,
    output logic [COL_W-1:0] col,
    output logic             last_beat
);
    logic [COL_W-1:0] blk_mask;
    logic [COL_W-1:0] seq_col;
    logic [COL_W-1:0] xor_col;

    // Mask of the column bits that move during the burst.
    always_comb begin
        if (full) blk_mask = '1;
        else      blk_mask = (COL_W'(1) << lg) - COL_W'(1);
    end

    // Form both orders and pick one.
    always_comb begin
        seq_col = base_col + beat;
        xor_col = base_col ^ beat;
        col     = (base_col & ~blk_mask) |
                  ((ilv ? xor_col : seq_col) & blk_mask);
    end

    // The final beat of a finite burst has all block bits counted.
    assign last_beat = !full && (beat == blk_mask);
endmodule

// File: rtl/sdram_col_burst_gen.sv
// Top of the SDRAM burst column sequencer: mode register, beat
// controller and column mapper.
// Assumes the mode is written only while the sequencer is idle.
module sdram_col_burst_gen
    import burst_col_pkg::*;
#(
    parameter int COL_W  = 8,
    parameter int MODE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_in,
    input  logic              start,
    input  logic [COL_W-1:0]  start_col,
    input  logic              start_wr,
    input  logic              stop_req,
    input  logic              pre_req,
    output logic [COL_W-1:0]  col_out,
    output logic              col_valid,
    output logic              col_last,
    output logic              mode_err
);
    burst_cfg_t       cfg;
    logic             active;
    logic [COL_W-1:0] beat;
    logic [COL_W-1:0] base_col;
    logic [1:0]       lg;
    logic             full;
    logic             ilv;
    logic             last_beat;

    burst_mode_reg #(.MODE_W(MODE_W)) u_mode (
        .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_in(mode_in),
        .cfg(cfg), .err(mode_err)
    );

    burst_beat_ctl #(.COL_W(COL_W)) u_ctl (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .start(start),
        .start_col(start_col), .start_wr(start_wr), .stop_req(stop_req),
        .pre_req(pre_req), .last_beat(last_beat), .active(active),
        .beat(beat), .base_col(base_col), .lg(lg), .full(full), .ilv(ilv)
    );

    burst_col_map #(.COL_W(COL_W)) u_map (
        .base_col(base_col), .beat(beat), .lg(lg), .full(full), .ilv(ilv),
        .col(col_out), .last_beat(last_beat)
    );

    assign col_valid = active;
    assign col_last  = active & last_beat;
endmodule

// File: rtl/burst_col_chk.sv
// Port-level properties of the burst column sequencer, bound to the top.
module burst_col_chk #(
    parameter int COL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [COL_W-1:0] start_col,
    input logic             stop_req,
    input logic             pre_req,
    input logic [COL_W-1:0] col_out,
    input logic             col_valid,
    input logic             col_last
);
    // R2
    last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        col_last |-> col_valid);

    // R2
    last_ends_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid && col_last && !start |=> !col_valid);

    // R6
    burst_continues_chk: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid && !col_last && !stop_req && !pre_req |=> col_valid);

    // R8
    stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req && !start |=> !col_valid);

    // R9
    pre_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pre_req && !start |=> !col_valid);

    // R12
    first_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> col_valid && col_out == $past(start_col));
endmodule

bind sdram_col_burst_gen burst_col_chk #(.COL_W(COL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .stop_req(stop_req), .pre_req(pre_req), .col_out(col_out),
    .col_valid(col_valid), .col_last(col_last)
);

// File: tb/sim_sdram_col_burst_gen.sv
`timescale 1ns/1ps
// Directed bench for the burst column sequencer.
module sim_sdram_col_burst_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_we = 1'b0;
    logic [9:0] mode_in = '0;
    logic       start = 1'b0;
    logic [7:0] start_col = '0;
    logic       start_wr = 1'b0;
    logic       stop_req = 1'b0;
    logic       pre_req = 1'b0;
    logic [7:0] col_out;
    logic       col_valid;
    logic       col_last;
    logic       mode_err;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sdram_col_burst_gen u0 (
        .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_in(mode_in),
        .start(start), .start_col(start_col), .start_wr(start_wr),
        .stop_req(stop_req), .pre_req(pre_req), .col_out(col_out),
        .col_valid(col_valid), .col_last(col_last), .mode_err(mode_err)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_col(int s, int i, int lg, bit il, bit fp);
        int len;
        if (fp) return (s + i) % 256;
        len = 1 << lg;
        if (il) return (s & ~(len - 1)) | ((s & (len - 1)) ^ i);
        return (s & ~(len - 1)) | ((s + i) % len);
    endfunction

    task automatic load_mode(input logic [9:0] m);
        @(negedge clk);
        mode_in = m; mode_we = 1'b1;
        @(negedge clk);
        mode_we = 1'b0;
        @(negedge clk);
    endtask

    // Run one burst: nchk beats checked; end_kind 0 natural, 1 stop, 2 precharge.
    task automatic run_burst(input string tag, input int s, input bit wr, input int lg,
                             input bit il, input bit fp, input int nchk, input int end_kind);
        start = 1'b1; start_col = 8'(s); start_wr = wr;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < nchk; i++) begin
            check(col_valid == 1'b1, tag, int'(col_valid), 1);
            check(int'(col_out) == exp_col(s, i, lg, il, fp), tag, int'(col_out),
                  exp_col(s, i, lg, il, fp));
            check(col_last == (!fp && end_kind == 0 && i == nchk - 1), tag,
                  int'(col_last), int'(!fp && end_kind == 0 && i == nchk - 1));
            if (i == nchk - 1) begin
                stop_req = (end_kind == 1);
                pre_req  = (end_kind == 2);
            end
            @(negedge clk);
            stop_req = 1'b0; pre_req = 1'b0;
        end
        check(col_valid == 1'b0, tag, int'(col_valid), 0);
        @(negedge clk);
    endtask

    task automatic t_reset();
        check(col_valid == 0 && col_last == 0 && mode_err == 0, "R1 reset",
              {col_valid, col_last, mode_err}, 0);
    endtask

    task automatic t_seq();
        load_mode(10'b0000000_010);                          // BL4 sequential
        check(mode_err == 0, "R2 legal mode", int'(mode_err), 0);
        run_burst("R3 seq bl4", 8'h42, 0, 2, 0, 0, 4, 0);    // R5: 0x42,43,40,41
        load_mode(10'b0000000_000);
        run_burst("R2 bl1", 8'h37, 0, 0, 0, 0, 1, 0);
        load_mode(10'b0000000_001);
        run_burst("R2 bl2", 8'h37, 0, 1, 0, 0, 2, 0);
        load_mode(10'b0000000_011);
        run_burst("R5 seq bl8", 8'hAD, 0, 3, 0, 0, 8, 0);
    endtask

    task automatic t_ilv();
        load_mode(10'b0000001_011);                          // BL8 interleave
        run_burst("R4 ilv bl8", 8'h01, 0, 3, 1, 0, 8, 0);
        load_mode(10'b0000001_010);
        run_burst("R4 ilv bl4", 8'h93, 0, 2, 1, 0, 4, 0);
    endtask

    task automatic t_page();
        load_mode(10'b0000000_111);
        run_burst("R6 full page", 8'hFE, 0, 0, 0, 1, 300, 1);
    endtask

    task automatic t_single_write();
        load_mode(10'b1000000_011);
        run_burst("R7 single write", 8'h14, 1, 0, 0, 0, 1, 0);
        run_burst("R7 read keeps bl8", 8'h14, 0, 3, 0, 0, 8, 0);
    endtask

    task automatic t_early_end();
        load_mode(10'b0000000_011);
        run_burst("R8 stop bl8", 8'h20, 0, 3, 0, 0, 3, 1);
        load_mode(10'b0000000_001);
        run_burst("R8 stop bl2", 8'h20, 0, 1, 0, 0, 1, 1);
        load_mode(10'b0000000_011);
        run_burst("R9 precharge bl8", 8'h50, 0, 3, 0, 0, 5, 2);
    endtask

    task automatic t_reserved();
        load_mode(10'b0000000_101);
        check(mode_err == 1, "R10 reserved err", int'(mode_err), 1);
        run_burst("R10 reserved bl1", 8'h66, 0, 0, 0, 0, 1, 0);
        load_mode(10'b0000001_111);
        check(mode_err == 1, "R11 page ilv err", int'(mode_err), 1);
        run_burst("R11 page seq", 8'h03, 0, 0, 0, 1, 10, 1);
        load_mode(10'b0000000_010);
        check(mode_err == 0, "R10 err clears", int'(mode_err), 0);
    endtask

    task automatic t_restart();
        load_mode(10'b0000000_011);
        start = 1'b1; start_col = 8'h10; start_wr = 1'b0;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        check(col_out == 8'h11, "R12 old burst", int'(col_out), 8'h11);
        start = 1'b1; start_col = 8'h25;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 8; i++) begin
            check(int'(col_out) == exp_col(8'h25, i, 3, 0, 0) && col_valid,
                  "R12 restart", int'(col_out), exp_col(8'h25, i, 3, 0, 0));
            @(negedge clk);
        end
        check(col_valid == 0, "R12 restart end", int'(col_valid), 0);
    endtask

    task automatic t_idle_stop();
        @(negedge clk);
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        check(col_valid == 0, "R13 idle stop", int'(col_valid), 0);
        pre_req = 1'b1;
        @(negedge clk);
        pre_req = 1'b0;
        check(col_valid == 0 && col_last == 0, "R13 idle precharge", int'(col_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_seq();
        t_ilv();
        t_page();
        t_single_write();
        t_early_end();
        t_reserved();
        t_restart();
        t_idle_stop();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog act=running exp=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule